// File: doc/BRIEF.md
# Serial EEPROM Word Reader

This block fetches a single 16-bit word from a three-wire serial EEPROM. A host presents a word address and an address-width select, then pulses a start request. The controller frames the access with chip select, clocks out a read command and the address, clocks in sixteen data bits, closes the frame, and hands back the word with a one-cycle done pulse.

Every serial-clock phase, high or low, is stretched to a fixed count of system clock cycles set by a parameter. This lets the same logic meet the slow minimum phase time of the memory at any system clock rate. The data-out pin from the memory passes through a two-stage synchronizer before it is sampled.

Top module: `serial_rom_reader`

## Requirements
- R1: After reset, chip select, serial clock, serial data-in, busy and done are all 0.
- R2: A frame opens by raising chip select while the serial clock and data-in are 0, then gives one full clock pulse with data-in at 0 before any command bit.
- R3: The read command is the three bits 1,1,0, sent most-significant first; each bit is placed on data-in during the low phase before its rising clock edge and stays unchanged while the clock is high.
- R4: After the command, the address is sent most-significant first: 8 bits (addr_i[7:0]) when wide_i is 1, and 6 bits (addr_i[5:0]) when wide_i is 0, with addr_i[7:6] ignored in that case.
- R5: After the address, exactly 16 rising clock edges occur with chip select high; data-out is sampled late in each high phase, most-significant bit first, and the assembled word appears on data_o.
- R6: Data-in is 0 at every rising clock edge of the data-reading part of the frame.
- R7: After the last data bit the clock returns low, then chip select falls with the clock and data-in at 0, then exactly one full clock pulse is given with chip select low and data-in at 0.
- R8: Every serial-clock high phase lasts exactly HALF_CYC system cycles, and every low phase inside a frame lasts at least HALF_CYC cycles.
- R9: A start request while busy is ignored: it neither changes the word returned nor begins another frame.
- R10: Busy is 1 from the cycle after an accepted start until done; done is a single-cycle pulse in the cycle busy falls, with data_o valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle read request |
| addr_i | input | 8 | Word address |
| wide_i | input | 1 | Address width select: 1 for 8 bits, 0 for 6 bits |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| data_o | output | 16 | Word read from the memory |
| cs_o | output | 1 | Chip select to the memory |
| sk_o | output | 1 | Serial clock to the memory |
| di_o | output | 1 | Serial data toward the memory |
| do_i | input | 1 | Serial data from the memory |

## Verification
The bench sweeps every address in both width modes against a behavioural memory whose contents are a computed function of the address. Each frame is checked for the command bits, the received address and the returned word. In 6-bit mode the address carries set upper bits, so a design that leaks them into the frame makes the memory answer for the wrong word. A design that drops or adds a pulse around chip select, or that samples data-out on the wrong edge, returns a word shifted by one bit. Phase lengths are measured on the pins to catch an off-by-one timer. A second start issued in mid-frame must leave the result and the done count unchanged; a design that restarts on it would open a second frame.

// File: rtl/srr_pkg.sv
package srr_pkg;

    localparam int          SRR_OPC_W = 3;
    localparam logic [2:0]  SRR_READ_OPC = 3'b110;

    typedef enum logic [3:0] {
        S_IDLE,
        S_SEL,
        S_WAKE_HI,
        S_WAKE_LO,
        S_OUT_LO,
        S_OUT_HI,
        S_IN_LO,
        S_IN_HI,
        S_TAIL_LO,
        S_CS_OFF,
        S_FIN_HI,
        S_FIN_LO
    } srr_state_e;

endpackage

// File: rtl/srr_half_timer.sv
module srr_half_timer #(
    parameter int HALF_CYC = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);
    localparam int CNT_W = $clog2(HALF_CYC + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_CYC - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick_o = run_i && (cnt_q == LAST);
        if (!run_i || tick_o) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assert_count_bounded_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
    assert_idle_count_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> cnt_q == '0);

endmodule

// File: rtl/srr_in_sync.sv
module srr_in_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] pipe_d, pipe_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb pipe_d = d_i;
        end else begin : g_chain
            always_comb pipe_d = {pipe_q[STAGES-2:0], d_i};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign q_o = pipe_q[STAGES-1];

endmodule

// File: rtl/srr_frame_fsm.sv
module srr_frame_fsm
    import srr_pkg::*;
#(
    parameter int ADDR_MAX = 8,
    parameter int ADDR_MIN = 6,
    parameter int DATA_W   = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [ADDR_MAX-1:0] addr_i,
    input  logic                wide_i,
    input  logic                tick_i,
    input  logic                sdo_i,
    output logic                run_o,
    output logic                busy_o,
    output logic                done_o,
    output logic [DATA_W-1:0]   data_o,
    output logic                cs_o,
    output logic                sk_o,
    output logic                di_o
);
    localparam int OUT_W = SRR_OPC_W + ADDR_MAX;
    localparam int MAXB  = (OUT_W > DATA_W) ? OUT_W : DATA_W;
    localparam int BIT_W = $clog2(MAXB + 1);
    localparam int PAD_W = ADDR_MAX - ADDR_MIN;

    typedef struct packed {
        srr_state_e          st;
        logic [OUT_W-1:0]    sh_out;
        logic [BIT_W-1:0]    bits;
        logic [DATA_W-1:0]   sh_in;
        logic [DATA_W-1:0]   data;
        logic                busy;
        logic                done;
        logic                cs;
        logic                sk;
        logic                di;
    } fsm_regs_t;

    fsm_regs_t r_q, r_d;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            S_IDLE: begin
                if (start_i) begin
                    r_d.st    = S_SEL;
                    r_d.busy  = 1'b1;
                    r_d.sh_in = '0;
                    if (wide_i) begin
                        r_d.sh_out = {SRR_READ_OPC, addr_i};
                        r_d.bits   = BIT_W'(SRR_OPC_W + ADDR_MAX);
                    end else begin
                        r_d.sh_out = {SRR_READ_OPC, addr_i[ADDR_MIN-1:0], {PAD_W{1'b0}}};
                        r_d.bits   = BIT_W'(SRR_OPC_W + ADDR_MIN);
                    end
                end
            end
            S_SEL:     if (tick_i) r_d.st = S_WAKE_HI;
            S_WAKE_HI: if (tick_i) r_d.st = S_WAKE_LO;
            S_WAKE_LO: if (tick_i) r_d.st = S_OUT_LO;
            S_OUT_LO:  if (tick_i) r_d.st = S_OUT_HI;
            S_OUT_HI: begin
                if (tick_i) begin
                    r_d.sh_out = r_q.sh_out << 1;
                    if (r_q.bits == BIT_W'(1)) begin
                        r_d.st   = S_IN_LO;
                        r_d.bits = BIT_W'(DATA_W);
                    end else begin
                        r_d.st   = S_OUT_LO;
                        r_d.bits = r_q.bits - BIT_W'(1);
                    end
                end
            end
            S_IN_LO:   if (tick_i) r_d.st = S_IN_HI;
            S_IN_HI: begin
                if (tick_i) begin
                    r_d.sh_in = {r_q.sh_in[DATA_W-2:0], sdo_i};
                    if (r_q.bits == BIT_W'(1)) begin
                        r_d.st = S_TAIL_LO;
                    end else begin
                        r_d.st   = S_IN_LO;
                        r_d.bits = r_q.bits - BIT_W'(1);
                    end
                end
            end
            S_TAIL_LO: if (tick_i) r_d.st = S_CS_OFF;
            S_CS_OFF:  if (tick_i) r_d.st = S_FIN_HI;
            S_FIN_HI:  if (tick_i) r_d.st = S_FIN_LO;
            S_FIN_LO: begin
                if (tick_i) begin
                    r_d.st   = S_IDLE;
                    r_d.busy = 1'b0;
                    r_d.done = 1'b1;
                    r_d.data = r_q.sh_in;
                end
            end
            default: r_d.st = S_IDLE;
        endcase

        r_d.cs = (r_d.st != S_IDLE) && (r_d.st != S_CS_OFF) &&
                 (r_d.st != S_FIN_HI) && (r_d.st != S_FIN_LO);
        r_d.sk = (r_d.st == S_WAKE_HI) || (r_d.st == S_OUT_HI) ||
                 (r_d.st == S_IN_HI)   || (r_d.st == S_FIN_HI);
        r_d.di = ((r_d.st == S_OUT_LO) || (r_d.st == S_OUT_HI)) ?
                 r_d.sh_out[OUT_W-1] : 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= S_IDLE;
        end else begin
            r_q    <= r_d;
        end
    end

    assign run_o  = (r_q.st != S_IDLE);
    assign busy_o = r_q.busy;
    assign done_o = r_q.done;
    assign data_o = r_q.data;
    assign cs_o   = r_q.cs;
    assign sk_o   = r_q.sk;
    assign di_o   = r_q.di;

    assert_frame_opens_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.cs) |-> (!r_q.sk && !r_q.di));
    assert_di_steady_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.sk && $past(r_q.sk)) |-> $stable(r_q.di));
    assert_frame_closes_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(r_q.cs) |-> (!r_q.sk && !r_q.di));
    assert_clock_moves_on_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(r_q.sk) |-> $past(tick_i));
    assert_start_while_busy_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.busy && start_i) |=> (r_q.st != S_SEL));
    assert_done_single_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.done |=> !r_q.done);
    assert_done_ends_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.done |-> (!r_q.busy && $past(r_q.busy)));

endmodule

// File: rtl/serial_rom_reader.sv
module serial_rom_reader #(
    parameter int HALF_CYC   = 125,
    parameter int ADDR_MAX   = 8,
    parameter int ADDR_MIN   = 6,
    parameter int DATA_W     = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [ADDR_MAX-1:0] addr_i,
    input  logic                wide_i,
    output logic                busy_o,
    output logic                done_o,
    output logic [DATA_W-1:0]   data_o,
    output logic                cs_o,
    output logic                sk_o,
    output logic                di_o,
    input  logic                do_i
);
    logic run;
    logic tick;
    logic sdo_s;

    srr_half_timer #(
        .HALF_CYC (HALF_CYC)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run),
        .tick_o (tick)
    );

    srr_in_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (do_i),
        .q_o   (sdo_s)
    );

    srr_frame_fsm #(
        .ADDR_MAX (ADDR_MAX),
        .ADDR_MIN (ADDR_MIN),
        .DATA_W   (DATA_W)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .addr_i  (addr_i),
        .wide_i  (wide_i),
        .tick_i  (tick),
        .sdo_i   (sdo_s),
        .run_o   (run),
        .busy_o  (busy_o),
        .done_o  (done_o),
        .data_o  (data_o),
        .cs_o    (cs_o),
        .sk_o    (sk_o),
        .di_o    (di_o)
    );

endmodule

// File: tb/serial_rom_reader_bench.sv
module serial_rom_reader_bench;
    localparam int HALF = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [7:0]  addr_i = '0;
    logic        wide_i = 1'b0;
    logic        busy_o, done_o, cs_o, sk_o, di_o;
    logic [15:0] data_o;
    logic        do_m = 1'b0;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    serial_rom_reader #(.HALF_CYC(HALF)) u_serial_rom_reader (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i),
        .wide_i(wide_i), .busy_o(busy_o), .done_o(done_o), .data_o(data_o),
        .cs_o(cs_o), .sk_o(sk_o), .di_o(di_o), .do_i(do_m)
    );

    function automatic logic [15:0] rom_word(input logic [7:0] a);
        return {a ^ 8'h5A, ~a};
    endfunction

    // behavioural memory
    int         aw_m = 8;
    int         rise_n = 0;
    int         fin_rises = 0;
    int         cs_opens = 0;
    logic [7:0] a_rx = '0;
    bit         pre_bad, opc_bad, rd_di_bad, open_bad, close_bad, fin_bad;

    always @(posedge cs_o) begin
        cs_opens++;
        rise_n = 0; a_rx = '0; fin_rises = 0;
        pre_bad = 0; opc_bad = 0; rd_di_bad = 0; close_bad = 0; fin_bad = 0;
        open_bad = sk_o || di_o;
    end

    always @(negedge cs_o) close_bad = close_bad || sk_o || di_o;

    always @(posedge sk_o) begin
        if (cs_o) begin
            if (rise_n == 0) begin
                pre_bad = pre_bad || di_o;
            end else if (rise_n <= 3) begin
                opc_bad = opc_bad || (di_o != (3'b110 >> (3 - rise_n)) % 2);
            end else if (rise_n <= 3 + aw_m) begin
                a_rx = {a_rx[6:0], di_o};
            end else begin
                logic [15:0] w;
                int k;
                w = rom_word(a_rx);
                k = rise_n - 4 - aw_m;
                rd_di_bad = rd_di_bad || di_o;
                if (k < 16) do_m <= w[15-k];
            end
            rise_n++;
        end else begin
            fin_rises++;
            fin_bad = fin_bad || di_o;
        end
    end

    // pin-level phase timing and done counting
    int  hi_len = 0, lo_len = 0, done_cnt = 0;
    bit  tim_bad = 0;
    logic sk_prev = 1'b0;
    always @(negedge clk) begin
        if (done_o) done_cnt++;
        if (sk_o && !sk_prev) begin
            if (cs_o && lo_len < HALF && lo_len != 0) tim_bad = 1;
            hi_len = 1;
        end else if (!sk_o && sk_prev) begin
            if (hi_len != HALF) tim_bad = 1;
            lo_len = 1;
        end else if (sk_o) begin
            hi_len++;
        end else begin
            lo_len++;
        end
        if (!busy_o) lo_len = 0;
        sk_prev = sk_o;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_done(output bit seen);
        seen = 0;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (done_o) begin seen = 1; break; end
        end
    endtask

    task automatic run_txn(input logic [7:0] a, input bit wide, input bit poke);
        logic [7:0] ea;
        bit seen;
        int d0;
        ea = wide ? a : {2'b00, a[5:0]};
        aw_m = wide ? 8 : 6;
        tim_bad = 0;
        d0 = done_cnt;
        @(negedge clk);
        start_i = 1'b1; addr_i = a; wide_i = wide;
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o == 1'b1, "R10 busy after start", busy_o, 1);
        if (poke) begin
            repeat (40) @(negedge clk);
            start_i = 1'b1; addr_i = ~a;
            @(negedge clk);
            start_i = 1'b0;
        end
        wait_done(seen);
        check(seen, "R10 done seen", seen, 1);
        check(!busy_o, "R10 busy low with done", busy_o, 0);
        check(data_o == rom_word(ea), "R5 data word", data_o, rom_word(ea));
        check(a_rx == ea, "R4 address bits", a_rx, ea);
        check(!opc_bad, "R3 read command 110", opc_bad, 0);
        check(!open_bad && !pre_bad, "R2 frame opening", {open_bad, pre_bad}, 0);
        check(rise_n == 4 + aw_m + 16, "R5 rising edge count", rise_n, 4 + aw_m + 16);
        check(!rd_di_bad, "R6 data-in low while reading", rd_di_bad, 0);
        check(!close_bad && fin_rises == 1 && !fin_bad, "R7 frame closing",
              fin_rises, 1);
        check(!tim_bad, "R8 phase lengths", tim_bad, 0);
        @(negedge clk);
        check(!done_o && done_cnt == d0 + 1, "R10 single done pulse", done_cnt - d0, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check({cs_o, sk_o, di_o, busy_o, done_o} == 5'b0, "R1 reset outputs",
              {cs_o, sk_o, di_o, busy_o, done_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check({cs_o, sk_o, di_o, busy_o, done_o} == 5'b0, "R1 idle after reset",
              {cs_o, sk_o, di_o, busy_o, done_o}, 0);
        // 6-bit mode, every address, upper bits set to prove R4 masking
        for (int a = 0; a < 64; a++) run_txn(8'(a) | 8'hC0, 1'b0, 1'b0);
        // 8-bit mode, every address
        for (int a = 0; a < 256; a++) run_txn(8'(a), 1'b1, 1'b0);
        // R9: start while busy is ignored
        begin
            int opens0, dc0;
            run_txn(8'h3C, 1'b1, 1'b1);
            opens0 = cs_opens;
            dc0 = done_cnt;
            repeat (300) @(negedge clk);
            check(cs_opens == opens0 && !busy_o, "R9 no second frame", cs_opens - opens0, 0);
            check(done_cnt == dc0, "R9 no extra done", done_cnt - dc0, 0);
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R10 watchdog actual=hung expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule